// File: doc/BRIEF.md
# Blinking Four-Letter Word Display Sequencer

This block drives a four-digit, seven-segment display so that the fixed lowercase word "radi" appears one letter per digit, and the whole word flashes on and off slowly. The seven segment lines are shared by all four digits, and each digit has its own enable line. The block time-multiplexes the four digits. A 2-bit state counter picks the current letter and the digit that shows it. It steps fast enough that all four letters look lit at the same time.

A single free-running prescaler provides two strobes. Its most significant bit is the blink phase. With the default 25-bit width and a 50 MHz clock, this phase runs at about 1.49 Hz. A lower tap of the prescaler gives the refresh tick that advances the state counter. During the dark half of each blink period, every digit enable is held at its off level. During the bright half, exactly one digit enable is on. The polarity of the enables and of the segment lines are both parameters.

Top module: `blink_word_display`

## Requirements
- R1: While the synchronous reset is high, and after it is released until the first bright phase, every digit enable is at its off level. The reset also returns the state counter to 00, so the segments show the letter r.
- R2: The blink phase is the most significant bit of a PRESCALE_W-bit prescaler that counts up on every clock from zero after reset. While that bit is 0, no digit enable is on.
- R3: While the blink phase bit is 1, exactly one of the four digit enables is on.
- R4: The state counter steps 00, 01, 10, 11 and then wraps to 00. It advances on the clock edge that ends a cycle in which the low REFRESH_W prescaler bits are all ones, so it advances once every 2^REFRESH_W cycles, and at no other time.
- R5: Digit enable vector bit 3 belongs to the leftmost digit. State 00 enables bit 3, state 01 enables bit 2, state 10 enables bit 1 and state 11 enables bit 0.
- R6: The segment vector places segment a in bit 0 through segment g in bit 6. The lit segments are: state 00 (r) lights e and g; state 01 (a) lights a, b, c, d, e and g; state 10 (d) lights b, c, d, e and g; state 11 (i) lights c only.
- R7: With the default segment polarity, a lit segment is driven 0 and an unlit segment is driven 1.
- R8: With the default enable polarity, an enabled digit is driven 1 and a disabled digit is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz in the target) |
| rst | input | 1 | Synchronous reset, active high |
| digitEn | output | 4 | Per-digit enables; bit 3 is the leftmost digit |
| segOut | output | 7 | Shared segment lines; bit 0 is a, bit 6 is g |

## Verification
The state counter can advance on the same clock edge that the blink phase switches from dark to bright. This happens because both events follow from the prescaler's low bits rolling over together. With power-of-two widths, every dark-to-bright edge is also a refresh tick. So the first bright cycle must already show the next letter on the next digit, and not a stale combination. The bench uses a reduced prescaler and runs through several blink periods, plus a reset in the middle of a bright phase. On every cycle it compares the enables and segments against a scoreboard model, and the edges where both events coincide are judged cycle-exactly.

// File: rtl/blink_word_pkg.sv
package blink_word_pkg;

  typedef struct packed {
    logic refreshTick;
    logic brightPhase;
  } ctrl_strobes_t;

  typedef enum logic [1:0] {
    LET_R = 2'b00,
    LET_A = 2'b01,
    LET_D = 2'b10,
    LET_I = 2'b11
  } letter_e;

  // lit-segment map, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] letterGlyph(input letter_e which);
    logic [6:0] glyph;
    case (which)
      LET_R:   glyph = 7'b101_0000;
      LET_A:   glyph = 7'b101_1111;
      LET_D:   glyph = 7'b101_1110;
      default: glyph = 7'b000_0100;
    endcase
    return glyph;
  endfunction

endpackage

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_word_pkg::*;
#(
  parameter int PRESCALE_W = 25,
  parameter int REFRESH_W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  output ctrl_strobes_t strobes
);

  localparam logic [REFRESH_W-1:0] LOW_FULL = '1;

  logic [PRESCALE_W-1:0] prescale;

  always_ff @(posedge clk) begin
    if (rst) prescale <= '0;
    else     prescale <= prescale + 1'b1;
  end

  always_comb begin
    strobes.brightPhase = prescale[PRESCALE_W-1];
    strobes.refreshTick = (prescale[REFRESH_W-1:0] == LOW_FULL);
  end

  initial begin
    tap_below_msb_chk: assert (REFRESH_W < PRESCALE_W && REFRESH_W > 0);
  end

  // R2
  phase_edge_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.brightPhase != $past(strobes.brightPhase)) |-> $past(strobes.refreshTick));

  // R1
  dark_after_reset_chk: assert property (@(posedge clk)
    $fell(rst) |-> !strobes.brightPhase);

endmodule

// File: rtl/blink_datapath.sv
module blink_datapath
  import blink_word_pkg::*;
#(
  parameter bit ENABLE_ON_HIGH = 1'b1,
  parameter bit SEG_ON_LOW     = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_strobes_t strobes,
  output logic [3:0]    digitEn,
  output logic [6:0]    segOut
);

  localparam int DIGITS = 4;

  letter_e     stateQ;
  logic [3:0]  rawEn;
  logic [6:0]  litSegs;

  always_ff @(posedge clk) begin
    if (rst)                      stateQ <= LET_R;
    else if (strobes.refreshTick) stateQ <= letter_e'(stateQ + 2'd1);
  end

  // each enable: decoded state AND blink phase
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    localparam logic [1:0] SEL = 2'(DIGITS - 1 - d);
    assign rawEn[d] = (stateQ == SEL) && strobes.brightPhase;
  end

  assign litSegs = letterGlyph(stateQ);

  generate
    if (ENABLE_ON_HIGH) begin : g_en_hi
      assign digitEn = rawEn;
    end else begin : g_en_lo
      assign digitEn = ~rawEn;
    end
    if (SEG_ON_LOW) begin : g_seg_lo
      assign segOut = ~litSegs;
    end else begin : g_seg_hi
      assign segOut = litSegs;
    end
  endgenerate

  // R2
  dark_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.brightPhase |-> (rawEn == 4'b0000));

  // R3
  single_digit_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.brightPhase |-> ($countones(rawEn) == 1));

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.refreshTick |=> $stable(stateQ));

  // R4
  step_state_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.refreshTick |=> (stateQ == letter_e'($past(stateQ) + 2'd1)));

endmodule

// File: rtl/blink_word_display.sv
module blink_word_display
  import blink_word_pkg::*;
#(
  parameter int PRESCALE_W     = 25,
  parameter int REFRESH_W      = 16,
  parameter bit ENABLE_ON_HIGH = 1'b1,
  parameter bit SEG_ON_LOW     = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] digitEn,
  output logic [6:0] segOut
);

  ctrl_strobes_t strobes;

  blink_ctrl #(
    .PRESCALE_W(PRESCALE_W),
    .REFRESH_W (REFRESH_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  blink_datapath #(
    .ENABLE_ON_HIGH(ENABLE_ON_HIGH),
    .SEG_ON_LOW    (SEG_ON_LOW)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .digitEn(digitEn),
    .segOut (segOut)
  );

endmodule

// File: tb/blink_word_display_test.sv
module blink_word_display_test;

  localparam int PW = 8;
  localparam int RW = 4;

  typedef struct {
    logic       inReset;
    logic       bright;
    logic [1:0] st;
    logic [3:0] en;
    logic [6:0] seg;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] digitEn;
  logic [6:0] segOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 1'b0;
  int coincide = 0;

  exp_t expQ[$];

  blink_word_display #(.PRESCALE_W(PW), .REFRESH_W(RW)) uut (
    .clk(clk), .rst(rst), .digitEn(digitEn), .segOut(segOut)
  );

  always #5 clk = ~clk;

  // R6 lit map from the requirement (bit0=a .. bit6=g)
  function automatic logic [6:0] litFor(input logic [1:0] s);
    case (s)
      2'b00:   return 7'b1010000;
      2'b01:   return 7'b1011111;
      2'b10:   return 7'b1011110;
      default: return 7'b0000100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  // driver/model: pushes expected outputs for the cycle after each edge
  logic [PW-1:0] mCnt = '0;
  logic [1:0]    mState = 2'b00;
  always @(posedge clk) begin
    exp_t e;
    logic prevBright;
    prevBright = mCnt[PW-1];
    if (rst) begin
      mCnt = '0;
      mState = 2'b00;
    end else begin
      if (mCnt[RW-1:0] == {RW{1'b1}}) mState = mState + 2'd1;
      mCnt = mCnt + 1'b1;
      if (!prevBright && mCnt[PW-1]) coincide++;
    end
    e.inReset = rst;
    e.bright  = mCnt[PW-1];
    e.st      = mState;
    e.en      = e.bright ? (4'b1000 >> mState) : 4'b0000;
    e.seg     = ~litFor(mState);
    expQ.push_back(e);
    cycles++;
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0 && !done) begin
      exp_t e;
      e = expQ.pop_front();
      if (e.inReset) begin
        check(digitEn == 4'b0000, "R1 enables off in reset", 16'(digitEn), 16'h0);
        check(segOut == ~7'b1010000, "R1 state 00 shows r", 16'(segOut), 16'(~7'b1010000));
      end else if (!e.bright) begin
        check(digitEn == 4'b0000, "R2 dark phase", 16'(digitEn), 16'h0);
      end else begin
        check($countones(digitEn) == 1, "R3 one digit lit", 16'(digitEn), 16'(e.en));
        check(digitEn == e.en, "R5 digit for state", 16'(digitEn), 16'(e.en));
        check(digitEn == (4'b1000 >> e.st), "R8 enable high when on", 16'(digitEn), 16'(e.en));
      end
      if (!e.inReset) begin
        check(segOut == e.seg, "R4 R6 letter sequence", 16'(segOut), 16'(e.seg));
        check($countones(~segOut) == $countones(litFor(e.st)), "R7 lit segment driven low",
              16'(segOut), 16'(e.seg));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3 * (1 << PW) + 20) @(negedge clk);
    // reset in the middle of a bright phase
    while (!uut.digitEn[0] && !uut.digitEn[1] && !uut.digitEn[2] && !uut.digitEn[3]) @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2 * (1 << PW) + 10) @(negedge clk);
    // R4 dark-to-bright edges coincide with a refresh step
    check(coincide >= 4, "R4 coinciding phase edges seen", 16'(coincide), 16'd4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule